// File: doc/BRIEF.md
# Banked Register File with Pointer Indirection

This block is the data register space of a small 8-bit controller core. The core reaches 32 locations through a 5-bit register address. A synchronous port with address, write data, write enable and combinational read data carries every access. The lower 16 addresses form one common area that every bank shares. The upper 16 addresses are backed by one of several RAM banks. The three most significant bits of a pointer register choose the bank.

The pointer register sits at a fixed address in the common area, so code can reach it from any bank. The alias address is address 0. An access to the alias address is sent to the location that the pointer's five low bits name, inside the bank that the pointer's high bits select. Code can therefore walk through memory by changing only the pointer. If the pointer names the alias address itself, a read returns zero and a write does nothing. Past plain storage, the special-function meaning of the low addresses is left to the surrounding core.

Top module: `banked_regfile`

## Requirements
- R1: After a synchronous active-low reset, every location and the pointer (address 4) read as zero.
- R2: A write to a direct address from 1 to 15 takes effect at the rising clock edge. Reading that address afterwards returns the value, whatever the bank bits are.
- R3: A direct access to an address from 16 to 31 reaches the bank given by pointer bits 7:5. Each of the 8 banks keeps its own contents.
- R4: A read of address 0 returns the location named by pointer bits 4:0. That location is taken from the common area when it is below 16, and from bank pointer[7:5] otherwise.
- R5: A write to address 0 with write enable stores the data in the location that R4 names for reads.
- R6: When pointer bits 4:0 equal 0, a read of address 0 returns zero and a write to address 0 changes no location.
- R7: The pointer is the common location at address 4. It can be written directly, or through address 0 when pointer bits 4:0 equal 4, and a new value changes bank selection from the next cycle on.
- R8: Read data follows the address combinationally. With write enable low, no location changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| we | input | 1 | Write enable |
| rdata | output | 8 | Read data for addr, combinational |

## Verification
Every piece of hidden state in this block can be read on rdata in the same cycle it is addressed. A wrong pointer value causes the most damage: in the cycle after it is written, a banked read or an alias read returns the contents of the wrong location. A corrupted RAM cell is harder to catch. It shows only when the bank and offset that hold it are read again, so the bench repeats a read of every address in every bank after each phase of stimulus.

// File: rtl/regfile_pkg.sv
// Package: shared widths and the resolved-access record for the banked register file.
// Assumes the pointer is exactly one data word wide and holds bank bits above address bits.
package regfile_pkg;
    localparam int RF_DATA_W  = 8;
    localparam int RF_ADDR_W  = 5;
    localparam int RF_BANK_W  = RF_DATA_W - RF_ADDR_W;
    localparam int RF_NBANK   = 1 << RF_BANK_W;
    localparam int RF_HALF    = 1 << (RF_ADDR_W - 1);
    localparam int RF_OFS_W   = RF_ADDR_W - 1;

    // Result of resolving one core access to a physical location.
    typedef struct packed {
        logic                 null_sel;  // alias pointing at itself
        logic                 common;    // lower half, shared by all banks
        logic [RF_BANK_W-1:0] bank;      // selected bank for upper half
        logic [RF_OFS_W-1:0]  ofs;       // offset inside the half
    } rf_target_t;
endpackage

// File: rtl/rf_addr_resolve.sv
// Module: rf_addr_resolve
// Maps a core address plus the pointer value to a physical target: alias redirection,
// common/banked split and bank choice. Purely combinational.
// Assumes the alias sits at ALIAS_ADDR and the pointer's high bits carry the bank.
module rf_addr_resolve
    import regfile_pkg::*;
#(
    parameter int ALIAS_ADDR = 0,
    parameter bit BANKED     = 1'b1
) (
    input  logic [RF_ADDR_W-1:0] addr,
    input  logic [RF_DATA_W-1:0] ptr,
    output rf_target_t           tgt
);
    logic [RF_ADDR_W-1:0] eff_addr;
    logic [RF_BANK_W-1:0] bank_sel;

    // Bank choice: pointer high bits when banking is enabled, else bank 0.
    generate
        if (BANKED) begin : g_bank
            assign bank_sel = ptr[RF_DATA_W-1 -: RF_BANK_W];
        end else begin : g_nobank
            assign bank_sel = '0;
        end
    endgenerate

    // Resolve alias redirection and split the effective address.
    always_comb begin
        eff_addr     = (addr == RF_ADDR_W'(ALIAS_ADDR)) ? ptr[RF_ADDR_W-1:0] : addr;
        tgt.null_sel = (eff_addr == RF_ADDR_W'(ALIAS_ADDR));
        tgt.common   = ~eff_addr[RF_ADDR_W-1];
        tgt.bank     = bank_sel;
        tgt.ofs      = eff_addr[RF_OFS_W-1:0];
    end
endmodule

// File: rtl/rf_common_regs.sv
// Module: rf_common_regs
// The lower-half locations shared by every bank, including the pointer register.
// Each location is its own register so the pointer can be tapped without a read port.
// Assumes writes arrive already resolved and gated; location ALIAS_ADDR is never written.
module rf_common_regs
    import regfile_pkg::*;
#(
    parameter int PTR_ADDR = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [RF_OFS_W-1:0]  wr_ofs,
    input  logic [RF_DATA_W-1:0] wr_data,
    input  logic [RF_OFS_W-1:0]  rd_ofs,
    output logic [RF_DATA_W-1:0] rd_data,
    output logic [RF_DATA_W-1:0] ptr
);
    logic [RF_DATA_W-1:0] regs [RF_HALF];

    generate
        for (genvar i = 0; i < RF_HALF; i++) begin : g_loc
            // Store one common location; cleared on reset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[i] <= '0;
                else if (wr_en && wr_ofs == RF_OFS_W'(i))
                    regs[i] <= wr_data;
            end
        end
    endgenerate

    assign rd_data = regs[rd_ofs];
    assign ptr     = regs[PTR_ADDR];
endmodule

// File: rtl/rf_bank_ram.sv
// Module: rf_bank_ram
// Upper-half storage: one row of RF_HALF words per bank, flat-indexed by {bank, offset}.
// Assumes a single write per cycle and combinational read.
module rf_bank_ram
    import regfile_pkg::*;
#(
    parameter int NBANK = RF_NBANK
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [RF_BANK_W-1:0] bank,
    input  logic [RF_OFS_W-1:0]  ofs,
    input  logic [RF_DATA_W-1:0] wr_data,
    output logic [RF_DATA_W-1:0] rd_data
);
    localparam int DEPTH = NBANK * RF_HALF;
    localparam int IDX_W = $clog2(DEPTH);

    logic [RF_DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]     idx;

    assign idx = IDX_W'({bank, ofs});

    // Write the selected word, or clear the whole array on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[idx] <= wr_data;
        end
    end

    assign rd_data = mem[idx];
endmodule

// File: rtl/banked_regfile.sv
// Module: banked_regfile (top)
// 32-address register file: common lower half, banked upper half, pointer/alias indirection.
// Assumes one access per cycle from the core; reads are combinational, writes on posedge.
module banked_regfile
    import regfile_pkg::*;
#(
    parameter int ALIAS_ADDR = 0,
    parameter int PTR_ADDR   = 4,
    parameter bit BANKED     = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [RF_ADDR_W-1:0] addr,
    input  logic [RF_DATA_W-1:0] wdata,
    input  logic                 we,
    output logic [RF_DATA_W-1:0] rdata
);
    rf_target_t           tgt;
    logic [RF_DATA_W-1:0] ptr_q;
    logic [RF_DATA_W-1:0] common_rd;
    logic [RF_DATA_W-1:0] bank_rd;
    logic                 wr_ok;

    rf_addr_resolve #(
        .ALIAS_ADDR (ALIAS_ADDR),
        .BANKED     (BANKED)
    ) u_resolve (
        .addr (addr),
        .ptr  (ptr_q),
        .tgt  (tgt)
    );

    // A write counts only when it does not land on the self-pointing alias.
    assign wr_ok = we && !tgt.null_sel;

    rf_common_regs #(
        .PTR_ADDR (PTR_ADDR)
    ) u_common (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok && tgt.common),
        .wr_ofs  (tgt.ofs),
        .wr_data (wdata),
        .rd_ofs  (tgt.ofs),
        .rd_data (common_rd),
        .ptr     (ptr_q)
    );

    rf_bank_ram #(
        .NBANK (RF_NBANK)
    ) u_banks (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok && !tgt.common),
        .bank    (tgt.bank),
        .ofs     (tgt.ofs),
        .wr_data (wdata),
        .rd_data (bank_rd)
    );

    // Read mux: zero for the self-pointing alias, else the half that holds the target.
    always_comb begin
        if (tgt.null_sel)
            rdata = '0;
        else if (tgt.common)
            rdata = common_rd;
        else
            rdata = bank_rd;
    end
endmodule

// File: rtl/banked_regfile_checks.sv
// Module: banked_regfile_checks
// Temporal checks on the pointer and the alias path, bound into banked_regfile.
module banked_regfile_checks
    import regfile_pkg::*;
#(
    parameter int ALIAS_ADDR = 0,
    parameter int PTR_ADDR   = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [RF_ADDR_W-1:0] addr,
    input logic [RF_DATA_W-1:0] wdata,
    input logic                 we,
    input logic [RF_DATA_W-1:0] rdata,
    input logic [RF_DATA_W-1:0] ptr_q
);
    logic via_alias;
    logic ptr_hit;
    assign via_alias = (addr == RF_ADDR_W'(ALIAS_ADDR));
    assign ptr_hit   = (addr == RF_ADDR_W'(PTR_ADDR)) ||
                       (via_alias && ptr_q[RF_ADDR_W-1:0] == RF_ADDR_W'(PTR_ADDR));

    // R6: self-pointing alias reads as zero
    assert_alias_self_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (via_alias && ptr_q[RF_ADDR_W-1:0] == RF_ADDR_W'(ALIAS_ADDR)) |-> rdata == '0);

    // R4: alias aimed at the pointer location returns the pointer
    assert_alias_reads_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (via_alias && ptr_q[RF_ADDR_W-1:0] == RF_ADDR_W'(PTR_ADDR)) |-> rdata == ptr_q);

    // R7: direct write to the pointer address loads the pointer
    assert_ptr_direct_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == RF_ADDR_W'(PTR_ADDR)) |=> ptr_q == $past(wdata));

    // R5: write through the alias onto the pointer location loads the pointer
    assert_ptr_alias_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && via_alias && ptr_q[RF_ADDR_W-1:0] == RF_ADDR_W'(PTR_ADDR)) |=> ptr_q == $past(wdata));

    // R8: pointer holds when no write targets it
    assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && ptr_hit) |=> $stable(ptr_q));
endmodule

bind banked_regfile banked_regfile_checks #(
    .ALIAS_ADDR (ALIAS_ADDR),
    .PTR_ADDR   (PTR_ADDR)
) u_checks (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .wdata (wdata),
    .we    (we),
    .rdata (rdata),
    .ptr_q (ptr_q)
);

// File: tb/tb_banked_regfile.sv
`timescale 1ns/1ps
// Bench: behavioural reference model of the 32-address banked file, compared every cycle.
module tb_banked_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       we = 1'b0;
    logic [7:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    int common_m [16];
    int bank_m [8][16];

    banked_regfile dut (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wdata (wdata),
        .we    (we),
        .rdata (rdata)
    );

    always #2.5 clk = ~clk;

    function automatic int m_ptr();
        return common_m[4];
    endfunction

    function automatic int m_target(input int a);
        return (a == 0) ? (m_ptr() & 31) : a;
    endfunction

    function automatic int m_read(input int a);
        int t = m_target(a);
        int b = (m_ptr() >> 5) & 7;
        if (t == 0) return 0;
        if (t < 16) return common_m[t];
        return bank_m[b][t-16];
    endfunction

    task automatic m_write(input int a, input int d);
        int t = m_target(a);
        int b = (m_ptr() >> 5) & 7;
        if (t == 0) return;
        if (t < 16) common_m[t] = d;
        else bank_m[b][t-16] = d;
    endtask

    task automatic m_clear();
        for (int i = 0; i < 16; i++) begin
            common_m[i] = 0;
            for (int b = 0; b < 8; b++) bank_m[b][i] = 0;
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s addr=%0d actual=%0h expected=%0h", req, addr, act, exp);
        end
    endtask

    // One access: drive after the falling edge, check read data, then commit at the rising edge.
    task automatic op(input string req, input int a, input int d, input bit w);
        @(negedge clk);
        addr = 5'(a); wdata = 8'(d); we = w;
        #1;
        check(req, int'(rdata), m_read(a));
        @(posedge clk);
        if (w) m_write(a, d);
    endtask

    // Read every address in every bank (pointer moved through the alias-free direct path).
    task automatic sweep(input string req);
        int saved = m_ptr();
        for (int b = 0; b < 8; b++) begin
            op("R7", 4, (b << 5) | (saved & 31), 1'b1);
            for (int a = 0; a < 32; a++) op(req, a, 0, 1'b0);
        end
        op("R7", 4, saved, 1'b1);
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_clear();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: everything zero after reset
        sweep("R1");
        // R2: common area independent of bank bits
        for (int a = 1; a < 16; a++) if (a != 4) op("R2", a, a * 7 + 3, 1'b1);
        op("R7", 4, 8'hE4, 1'b1);
        for (int a = 1; a < 16; a++) op("R2", a, 0, 1'b0);
        // R3: distinct data per bank in upper half
        for (int b = 0; b < 8; b++) begin
            op("R7", 4, (b << 5) | 4, 1'b1);
            for (int a = 16; a < 32; a++) op("R3", a, (b * 16 + a) ^ 8'h5A, 1'b1);
        end
        sweep("R3");
        // R4/R5: alias reaches common and banked targets
        op("R7", 4, (3 << 5) | 20, 1'b1);
        op("R4", 0, 0, 1'b0);
        op("R5", 0, 8'hC3, 1'b1);
        op("R4", 20, 0, 1'b0);
        op("R7", 4, 9, 1'b1);
        op("R5", 0, 8'h99, 1'b1);
        op("R4", 9, 0, 1'b0);
        // R6: self-pointing alias reads zero and write is dropped
        op("R7", 4, 8'hA0, 1'b1);
        op("R6", 0, 0, 1'b0);
        op("R6", 0, 8'h77, 1'b1);
        op("R6", 0, 0, 1'b0);
        sweep("R6");
        // R7: pointer rewritten through the alias
        op("R7", 4, (5 << 5) | 4, 1'b1);
        op("R7", 0, (2 << 5) | 17, 1'b1);
        op("R7", 4, 0, 1'b0);
        op("R7", 0, 0, 1'b0);
        op("R7", 17, 0, 1'b0);
        // R8: writes gated by enable, random mix afterwards
        for (int i = 0; i < 40; i++) op("R8", i % 32, 8'hFF, 1'b0);
        for (int i = 0; i < 4000; i++) begin
            int a = $urandom_range(0, 31);
            op("R8", a, $urandom_range(0, 255), 1'($urandom_range(0, 1)));
        end
        sweep("R8");
        // R1: reset again clears all
        @(negedge clk); rst_n = 1'b0; we = 1'b0;
        @(posedge clk); m_clear();
        @(negedge clk); rst_n = 1'b1;
        sweep("R1");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule